// File: doc/BRIEF.md
# Multi-Mode Raster Video Generator

This block produces a complete raster: it counts clocks and lines, raises horizontal and vertical sync and a frame interrupt, fetches bytes from video RAM through a plain read port, and turns them into colour indices. One clock is one standard pixel. The picture area is 256x192 in the standard modes, or 512x192 in the double-width mode, which emits two pixels per clock. Outside the picture a border colour is shown, and during either sync window the colour is forced to black.

Four modes are selected by a 3-bit code. The first standard mode reads bitmap and attributes from the first screen. The second reads the same layout 8 KiB higher. The fine-colour mode reads its bitmap from the first screen and gives one attribute per 8x1 cell, taken from the same offset in the second screen's bitmap area. The double-width mode interleaves 8-pixel columns from both bitmap areas and uses a fixed bright ink/paper pair picked by a second 3-bit code. A one-bit bank select picks which of two 16 KiB RAM banks the fetches go to. The mode is sampled at the start of each 8-pixel fetch group, so software can change it part-way down a frame to split the screen.

Fetching is run by a state machine with nine states. F_IDLE waits for the fetch trigger eight clocks before the picture; F_REQ_A puts out the bitmap address; F_WAIT_A covers the RAM latency; F_TAKE_A captures the bitmap byte and puts out the second address (attribute or second bitmap); F_WAIT_B waits; F_TAKE_B captures the second byte; F_GAP_1 and F_GAP_2 pad the group; F_LOAD hands both bytes to the pixel shifter. From F_LOAD it goes to F_REQ_A if columns remain on the line, otherwise to F_IDLE. Every other transition is unconditional.

Top module: `multimode_video`

## Requirements
- R1: A line lasts LINE_CLKS clocks and a frame FRAME_LINES lines. hsync is high for HS_LEN clocks from clock HS_START of every line. vsync is high for VS_LEN whole lines from line VS_START. All outputs are registered, so an output describes the position of the counters one clock earlier.
- R2: mode_sel with bit1 = 0 and bit0 = 0 selects the first standard screen. The bitmap byte for picture line y and column c is at offset {y[7:6], y[2:0], y[5:3], c[4:0]}, and the attribute is at offset 0x1800 + 32*(y/8) + c. In an attribute, bits 2:0 are ink, bits 5:3 are paper and bit 6 is bright. The pixel is the bitmap bit from MSB to LSB, and colour = {bright, set ? ink : paper}. colour_a equals colour_b. Read data is returned one clock after the address.
- R3: mode_sel with bit1 = 0 and bit0 = 1 selects the second standard screen: the same layout at offset + 0x2000.
- R4: mode_sel = 010 (bit1 = 1, bit2 = 0) is fine-colour mode. The bitmap comes from the first screen's bitmap offset, and the attribute from that same offset + 0x2000.
- R5: mode_sel with bit1 = 1 and bit2 = 1 is double-width mode. Each column gives 16 pixels, the first 8 from the byte at the bitmap offset and the next 8 from the byte at offset + 0x2000. Two pixels come out per clock, colour_a first. No attribute is read.
- R6: In double-width mode, with s = hires_pair, ink is s and paper is 7 - s, every colour has the bright bit set, and the border is {1, 7 - s}.
- R7: mem_bank equals alt_bank as sampled at the start of each fetch group, so every video read goes to the selected bank.
- R8: mode_sel is sampled at the start of each fetch group, so a change made during horizontal blanking takes effect on the next line.
- R9: frame_irq is high for the first INT_LEN clocks of line 0 of each frame, except where irq_mask was high the clock before.
- R10: In the two standard modes and in fine-colour mode, attribute bit 7 swaps ink and paper during every second run of FLASH_FRAMES frames. The first run after reset is not swapped.
- R11: Outside the picture, the colour is {0, border_idx} in non-double-width modes. While hsync or vsync is high, both colours are 0.
- R12: During reset, the colours, the sync flags, frame_irq, mem_addr and mem_bank are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Screen mode code |
| hires_pair | input | 3 | Ink/paper pair for double-width mode |
| alt_bank | input | 1 | Selects the second 16 KiB video bank |
| border_idx | input | 3 | Border colour index |
| irq_mask | input | 1 | Suppresses the frame interrupt |
| mem_addr | output | 14 | Byte offset within the video bank |
| mem_bank | output | 1 | Bank for the current read |
| mem_data | input | 8 | Read data, one clock after the address |
| colour_a | output | 4 | First pixel of the clock {bright, index} |
| colour_b | output | 4 | Second pixel of the clock {bright, index} |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| frame_irq | output | 1 | Frame interrupt pulse |

## Verification
The bench builds the block with a reduced raster: 64-clock lines, 24-line frames, a 4-column by 16-line picture and a 10-clock interrupt, keeping the 16-frame flash period. With these values, 34 frames fit in the run. This covers every mode code (including the aliases 100, 111 and 011), both banks, a frame split from fine-colour to double-width mode, masked and unmasked interrupts, and both flash phases. The bench's RAM returns a hash of the full bank/offset address, so any fetch from a wrong address shows up as a wrong pixel.

// File: rtl/mmv_pkg.sv
package mmv_pkg;

    typedef enum logic [1:0] {
        VK_SCR0,
        VK_SCR1,
        VK_HICOL,
        VK_HIRES
    } vkind_t;

    typedef enum logic [3:0] {
        F_IDLE,
        F_REQ_A,
        F_WAIT_A,
        F_TAKE_A,
        F_WAIT_B,
        F_TAKE_B,
        F_GAP_1,
        F_GAP_2,
        F_LOAD
    } fstate_t;

    function automatic vkind_t decode_mode(input logic [2:0] m);
        if (!m[1])
            return m[0] ? VK_SCR1 : VK_SCR0;
        else if (!m[2])
            return VK_HICOL;
        else
            return VK_HIRES;
    endfunction

    // bitmap byte offset: thirds, pixel row in cell, cell row, column
    function automatic logic [12:0] pix_ofs(input logic [7:0] y, input logic [4:0] col);
        return {y[7:6], y[2:0], y[5:3], col};
    endfunction

    // attribute byte offset after the 6 KiB bitmap
    function automatic logic [12:0] attr_ofs(input logic [7:0] y, input logic [4:0] col);
        return {3'b110, y[7:3], col};
    endfunction

endpackage

// File: rtl/mmv_timing.sv
module mmv_timing #(
    parameter int LINE_CLKS    = 448,
    parameter int FRAME_LINES  = 312,
    parameter int H_ACT_START  = 48,
    parameter int ACT_COLS     = 32,
    parameter int V_ACT_START  = 56,
    parameter int ACT_LINES    = 192,
    parameter int HS_START     = 352,
    parameter int HS_LEN       = 32,
    parameter int VS_START     = 280,
    parameter int VS_LEN       = 4,
    parameter int INT_LEN      = 64,
    parameter int FLASH_FRAMES = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           irq_mask,
    output logic [$clog2(FRAME_LINES)-1:0] vc,
    output logic                           kick,
    output logic                           disp_act,
    output logic                           hs_win,
    output logic                           vs_win,
    output logic                           flash_ph,
    output logic                           hsync,
    output logic                           vsync,
    output logic                           frame_irq
);
    localparam int HW = $clog2(LINE_CLKS);
    localparam int VW = $clog2(FRAME_LINES);
    localparam int FW = (FLASH_FRAMES > 1) ? $clog2(FLASH_FRAMES) : 1;

    localparam logic [HW-1:0] H_LAST = HW'(LINE_CLKS - 1);
    localparam logic [HW-1:0] HA_S   = HW'(H_ACT_START);
    localparam logic [HW-1:0] HE_S   = HW'(H_ACT_START + 8 * ACT_COLS);
    localparam logic [HW-1:0] KICK_S = HW'(H_ACT_START - 9);
    localparam logic [HW-1:0] HS0_S  = HW'(HS_START);
    localparam logic [HW-1:0] HS1_S  = HW'(HS_START + HS_LEN);
    localparam logic [HW-1:0] INT_S  = HW'(INT_LEN);
    localparam logic [VW-1:0] V_LAST = VW'(FRAME_LINES - 1);
    localparam logic [VW-1:0] VA_S   = VW'(V_ACT_START);
    localparam logic [VW-1:0] VE_S   = VW'(V_ACT_START + ACT_LINES);
    localparam logic [VW-1:0] VS0_S  = VW'(VS_START);
    localparam logic [VW-1:0] VS1_S  = VW'(VS_START + VS_LEN);
    localparam logic [FW-1:0] FL_LAST = FW'(FLASH_FRAMES - 1);

    logic [HW-1:0] hc;
    logic [FW-1:0] fl_cnt;
    logic          line_act;
    logic          frame_end;

    assign line_act  = (vc >= VA_S) && (vc < VE_S);
    assign kick      = line_act && (hc == KICK_S);
    assign disp_act  = line_act && (hc >= HA_S) && (hc < HE_S);
    assign hs_win    = (hc >= HS0_S) && (hc < HS1_S);
    assign vs_win    = (vc >= VS0_S) && (vc < VS1_S);
    assign frame_end = (hc == H_LAST) && (vc == V_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hc <= '0;
            vc <= '0;
        end else if (hc == H_LAST) begin
            hc <= '0;
            vc <= (vc == V_LAST) ? '0 : vc + 1'b1;
        end else begin
            hc <= hc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_cnt   <= '0;
            flash_ph <= 1'b0;
        end else if (frame_end) begin
            if (fl_cnt == FL_LAST) begin
                fl_cnt   <= '0;
                flash_ph <= ~flash_ph;
            end else begin
                fl_cnt <= fl_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hsync     <= 1'b0;
            vsync     <= 1'b0;
            frame_irq <= 1'b0;
        end else begin
            hsync     <= hs_win;
            vsync     <= vs_win;
            frame_irq <= (vc == '0) && (hc < INT_S) && !irq_mask;
        end
    end

endmodule

// File: rtl/mmv_fetch.sv
module mmv_fetch
    import mmv_pkg::*;
#(
    parameter int FRAME_LINES = 312,
    parameter int V_ACT_START = 56,
    parameter int ACT_COLS    = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           kick,
    input  logic [$clog2(FRAME_LINES)-1:0] vc,
    input  logic [2:0]                     mode_sel,
    input  logic                           alt_bank,
    input  logic [7:0]                     mem_data,
    output logic [13:0]                    mem_addr,
    output logic                           mem_bank,
    output logic                           ld,
    output logic [7:0]                     b_pix,
    output logic [7:0]                     b_sec,
    output vkind_t                         f_kind
);
    localparam int VW = $clog2(FRAME_LINES);
    localparam int CW = (ACT_COLS > 1) ? $clog2(ACT_COLS) : 1;
    localparam logic [VW-1:0] VA_S     = VW'(V_ACT_START);
    localparam logic [CW-1:0] COL_LAST = CW'(ACT_COLS - 1);

    fstate_t       state, state_nx;
    logic [CW-1:0] col;
    logic [7:0]    y;
    logic [12:0]   p_ofs;
    vkind_t        kind_now;

    assign y        = 8'(vc - VA_S);
    assign p_ofs    = pix_ofs(y, 5'(col));
    assign kind_now = decode_mode(mode_sel);
    assign ld       = (state == F_LOAD);

    always_comb begin
        state_nx = state;
        unique case (state)
            F_IDLE:   state_nx = kick ? F_REQ_A : F_IDLE;
            F_REQ_A:  state_nx = F_WAIT_A;
            F_WAIT_A: state_nx = F_TAKE_A;
            F_TAKE_A: state_nx = F_WAIT_B;
            F_WAIT_B: state_nx = F_TAKE_B;
            F_TAKE_B: state_nx = F_GAP_1;
            F_GAP_1:  state_nx = F_GAP_2;
            F_GAP_2:  state_nx = F_LOAD;
            F_LOAD:   state_nx = (col == COL_LAST) ? F_IDLE : F_REQ_A;
            default:  state_nx = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= F_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col      <= '0;
            mem_addr <= '0;
            mem_bank <= 1'b0;
            b_pix    <= '0;
            b_sec    <= '0;
            f_kind   <= VK_SCR0;
        end else begin
            unique case (state)
                F_IDLE: col <= '0;
                F_REQ_A: begin
                    f_kind   <= kind_now;
                    mem_bank <= alt_bank;
                    mem_addr <= {kind_now == VK_SCR1, p_ofs};
                end
                F_TAKE_A: begin
                    b_pix <= mem_data;
                    if (f_kind == VK_SCR0 || f_kind == VK_SCR1)
                        mem_addr <= {f_kind == VK_SCR1, attr_ofs(y, 5'(col))};
                    else
                        mem_addr <= {1'b1, p_ofs};
                end
                F_TAKE_B: b_sec <= mem_data;
                F_LOAD:   col <= col + 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mmv_pixel.sv
module mmv_pixel
    import mmv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld,
    input  logic [7:0] b_pix,
    input  logic [7:0] b_sec,
    input  vkind_t     f_kind,
    input  logic       disp_act,
    input  logic       hs_win,
    input  logic       vs_win,
    input  logic       flash_ph,
    input  logic [2:0] mode_sel,
    input  logic [2:0] hires_pair,
    input  logic [2:0] border_idx,
    output logic [3:0] colour_a,
    output logic [3:0] colour_b
);
    logic [15:0] sh;
    logic [7:0]  d_attr;
    vkind_t      d_kind;
    logic [3:0]  ink_c, paper_c, std_c, hr_ink, hr_paper, border_c;
    logic        std_bit;

    assign ink_c    = {d_attr[6], d_attr[2:0]};
    assign paper_c  = {d_attr[6], d_attr[5:3]};
    assign std_bit  = sh[15] ^ (d_attr[7] & flash_ph);
    assign std_c    = std_bit ? ink_c : paper_c;
    assign hr_ink   = {1'b1, hires_pair};
    assign hr_paper = {1'b1, ~hires_pair};
    assign border_c = (decode_mode(mode_sel) == VK_HIRES) ? hr_paper : {1'b0, border_idx};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            d_attr <= '0;
            d_kind <= VK_SCR0;
        end else if (ld) begin
            sh     <= {b_pix, b_sec};
            d_attr <= b_sec;
            d_kind <= f_kind;
        end else if (disp_act) begin
            sh <= (d_kind == VK_HIRES) ? {sh[13:0], 2'b00} : {sh[14:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            colour_a <= '0;
            colour_b <= '0;
        end else if (hs_win || vs_win) begin
            colour_a <= '0;
            colour_b <= '0;
        end else if (disp_act) begin
            if (d_kind == VK_HIRES) begin
                colour_a <= sh[15] ? hr_ink : hr_paper;
                colour_b <= sh[14] ? hr_ink : hr_paper;
            end else begin
                colour_a <= std_c;
                colour_b <= std_c;
            end
        end else begin
            colour_a <= border_c;
            colour_b <= border_c;
        end
    end

endmodule

// File: rtl/multimode_video.sv
module multimode_video
    import mmv_pkg::*;
#(
    parameter int LINE_CLKS    = 448,
    parameter int FRAME_LINES  = 312,
    parameter int H_ACT_START  = 48,
    parameter int ACT_COLS     = 32,
    parameter int V_ACT_START  = 56,
    parameter int ACT_LINES    = 192,
    parameter int HS_START     = 352,
    parameter int HS_LEN       = 32,
    parameter int VS_START     = 280,
    parameter int VS_LEN       = 4,
    parameter int INT_LEN      = 64,
    parameter int FLASH_FRAMES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  mode_sel,
    input  logic [2:0]  hires_pair,
    input  logic        alt_bank,
    input  logic [2:0]  border_idx,
    input  logic        irq_mask,
    output logic [13:0] mem_addr,
    output logic        mem_bank,
    input  logic [7:0]  mem_data,
    output logic [3:0]  colour_a,
    output logic [3:0]  colour_b,
    output logic        hsync,
    output logic        vsync,
    output logic        frame_irq
);
    localparam int VW = $clog2(FRAME_LINES);

    logic [VW-1:0] vc;
    logic          kick, disp_act, hs_win, vs_win, flash_ph, ld;
    logic [7:0]    b_pix, b_sec;
    vkind_t        f_kind;

    mmv_timing #(
        .LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES),
        .H_ACT_START(H_ACT_START), .ACT_COLS(ACT_COLS),
        .V_ACT_START(V_ACT_START), .ACT_LINES(ACT_LINES),
        .HS_START(HS_START), .HS_LEN(HS_LEN),
        .VS_START(VS_START), .VS_LEN(VS_LEN),
        .INT_LEN(INT_LEN), .FLASH_FRAMES(FLASH_FRAMES)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .irq_mask(irq_mask), .vc(vc),
        .kick(kick), .disp_act(disp_act), .hs_win(hs_win), .vs_win(vs_win),
        .flash_ph(flash_ph), .hsync(hsync), .vsync(vsync), .frame_irq(frame_irq)
    );

    mmv_fetch #(
        .FRAME_LINES(FRAME_LINES), .V_ACT_START(V_ACT_START), .ACT_COLS(ACT_COLS)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .kick(kick), .vc(vc), .mode_sel(mode_sel),
        .alt_bank(alt_bank), .mem_data(mem_data), .mem_addr(mem_addr),
        .mem_bank(mem_bank), .ld(ld), .b_pix(b_pix), .b_sec(b_sec), .f_kind(f_kind)
    );

    mmv_pixel u_pixel (
        .clk(clk), .rst_n(rst_n), .ld(ld), .b_pix(b_pix), .b_sec(b_sec),
        .f_kind(f_kind), .disp_act(disp_act), .hs_win(hs_win), .vs_win(vs_win),
        .flash_ph(flash_ph), .mode_sel(mode_sel), .hires_pair(hires_pair),
        .border_idx(border_idx), .colour_a(colour_a), .colour_b(colour_b)
    );

endmodule

// File: rtl/mmv_checker.sv
module mmv_checker #(
    parameter int HS_LEN  = 32,
    parameter int INT_LEN = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_mask,
    input logic       hsync,
    input logic       vsync,
    input logic       frame_irq,
    input logic [3:0] colour_a,
    input logic [3:0] colour_b
);
    localparam int IW = $clog2(INT_LEN + 2);
    localparam int SW = $clog2(HS_LEN + 2);

    logic [IW-1:0] irq_run;
    logic [SW-1:0] hs_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_run <= '0;
            hs_run  <= '0;
        end else begin
            irq_run <= frame_irq ? ((irq_run == '1) ? irq_run : irq_run + 1'b1) : '0;
            hs_run  <= hsync ? ((hs_run == '1) ? hs_run : hs_run + 1'b1) : '0;
        end
    end

    // R11: black during sync
    p_sync_blank_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync || vsync) |-> (colour_a == 4'd0 && colour_b == 4'd0));

    // R9: mask blocks the pulse on the following clock
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |=> !frame_irq);

    // R9: pulse never longer than INT_LEN clocks
    p_irq_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_irq |-> (irq_run < IW'(INT_LEN)));

    // R1: horizontal sync never longer than HS_LEN clocks
    p_hsync_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> (hs_run < SW'(HS_LEN)));

endmodule

bind multimode_video mmv_checker #(.HS_LEN(HS_LEN), .INT_LEN(INT_LEN)) u_mmv_chk (
    .clk(clk), .rst_n(rst_n), .irq_mask(irq_mask), .hsync(hsync), .vsync(vsync),
    .frame_irq(frame_irq), .colour_a(colour_a), .colour_b(colour_b)
);

// File: tb/multimode_video_test.sv
module multimode_video_test;
    localparam int CLK_P   = 10;
    localparam int LINE    = 64;
    localparam int FL      = 24;
    localparam int HA      = 12;
    localparam int COLS    = 4;
    localparam int VA      = 4;
    localparam int LINES   = 16;
    localparam int HS      = 50;
    localparam int HSL     = 6;
    localparam int VS      = 21;
    localparam int VSL     = 2;
    localparam int INTL    = 10;
    localparam int FLASH   = 16;
    localparam int NFRAMES = 34;
    localparam int SAFE_H  = 46;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_sel = 3'b000;
    logic [2:0]  hires_pair = 3'd0;
    logic        alt_bank = 1'b0;
    logic [2:0]  border_idx = 3'd0;
    logic        irq_mask = 1'b0;
    logic [13:0] mem_addr;
    logic        mem_bank;
    logic [7:0]  mem_data = 8'd0;
    logic [3:0]  colour_a, colour_b;
    logic        hsync, vsync, frame_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    multimode_video #(
        .LINE_CLKS(LINE), .FRAME_LINES(FL), .H_ACT_START(HA), .ACT_COLS(COLS),
        .V_ACT_START(VA), .ACT_LINES(LINES), .HS_START(HS), .HS_LEN(HSL),
        .VS_START(VS), .VS_LEN(VSL), .INT_LEN(INTL), .FLASH_FRAMES(FLASH)
    ) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .hires_pair(hires_pair),
        .alt_bank(alt_bank), .border_idx(border_idx), .irq_mask(irq_mask),
        .mem_addr(mem_addr), .mem_bank(mem_bank), .mem_data(mem_data),
        .colour_a(colour_a), .colour_b(colour_b), .hsync(hsync), .vsync(vsync),
        .frame_irq(frame_irq)
    );

    // RAM contents: a hash of the 15-bit bank/offset address
    function automatic logic [7:0] memf(input int a);
        return 8'(a * 37) ^ 8'(a >>> 7) ^ 8'h5A;
    endfunction

    always_ff @(posedge clk) mem_data <= memf(int'({mem_bank, mem_addr}));

    task automatic check(input string tag, input int act, input int exp, input int pos);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s pos %0d: actual %0h expected %0h", tag, pos, act, exp);
        end
    endtask

    // stimulus schedule per frame and line
    task automatic cfg(input int f, input int l);
        hires_pair = 3'd2;
        alt_bank   = 1'b1;
        border_idx = 3'd1;
        mode_sel   = 3'b000;
        irq_mask   = (f == 5) || (f == 20);           // R9 masked frames
        case (f)
            0: begin mode_sel = 3'b000; alt_bank = 1'b0; border_idx = 3'd2; end
            1: begin mode_sel = 3'b001; border_idx = 3'd5; end       // R3
            2: begin mode_sel = 3'b010; alt_bank = 1'b0; border_idx = 3'd3; end // R4
            3: begin mode_sel = 3'b110; hires_pair = 3'd3; end       // R5, R6
            4: begin                                                 // R8 split
                alt_bank = 1'b0;
                if (l < 10) mode_sel = 3'b010;
                else begin mode_sel = 3'b110; hires_pair = 3'd5; end
            end
            5: begin mode_sel = 3'b100; border_idx = 3'd7; end
            6: begin mode_sel = 3'b111; hires_pair = 3'd0; end
            7: begin mode_sel = 3'b011; hires_pair = 3'd6; border_idx = 3'd4; end
            default: ;                                               // R7, R10
        endcase
    endtask

    task automatic model(input int q, output logic [3:0] ea, output logic [3:0] eb,
                         output logic ehs, output logic evs, output logic eirq,
                         output string tag);
        int h, v, f, y, col, k, pofs, aofs, bk, base;
        logic [7:0] pix, at;
        logic [15:0] w;
        logic fl, hires, hicol, scr1, bit_v;
        h = q % LINE;
        v = (q / LINE) % FL;
        f = q / (LINE * FL);
        ehs = (h >= HS) && (h < HS + HSL);
        evs = (v >= VS) && (v < VS + VSL);
        eirq = (v == 0) && (h < INTL) && !irq_mask;
        hires = mode_sel[1] & mode_sel[2];
        hicol = mode_sel[1] & !mode_sel[2];
        scr1  = !mode_sel[1] & mode_sel[0];
        fl = ((f / FLASH) % 2) == 1;
        if (ehs || evs) begin
            ea = 4'd0; eb = 4'd0; tag = "R11";
        end else if (v >= VA && v < VA + LINES && h >= HA && h < HA + 8 * COLS) begin
            y = v - VA; col = (h - HA) / 8; k = (h - HA) % 8;
            pofs = ((y >> 6) << 11) | ((y & 7) << 8) | (((y >> 3) & 7) << 5) | col;
            aofs = 32'h1800 | ((y >> 3) << 5) | col;
            bk = alt_bank ? 16384 : 0;
            if (hires) begin
                w = {memf(bk + pofs), memf(bk + 8192 + pofs)};
                ea = {1'b1, w[15 - 2 * k] ? hires_pair : 3'(7 - hires_pair)};
                eb = {1'b1, w[14 - 2 * k] ? hires_pair : 3'(7 - hires_pair)};
                tag = "R5";
            end else begin
                if (hicol) begin
                    pix = memf(bk + pofs); at = memf(bk + 8192 + pofs); tag = "R4";
                end else begin
                    base = scr1 ? 8192 : 0;
                    pix = memf(bk + base + pofs); at = memf(bk + base + aofs);
                    tag = scr1 ? "R3" : ((f >= 8) ? "R7" : "R2");
                end
                if (at[7] && fl) tag = "R10";
                bit_v = pix[7 - k] ^ (at[7] & fl);
                ea = {at[6], bit_v ? at[2:0] : at[5:3]};
                eb = ea;
            end
            if (f == 4) tag = "R8";
        end else begin
            ea = hires ? {1'b1, 3'(7 - hires_pair)} : {1'b0, border_idx};
            eb = ea;
            tag = hires ? "R6" : "R11";
        end
    endtask

    initial begin
        logic [3:0] ea, eb;
        logic ehs, evs, eirq;
        string tag;
        int h, l, f;
        cfg(0, 0);
        repeat (3) begin
            @(negedge clk);
            // R12 reset state
            check("R12", int'({colour_a, colour_b}), 0, -1);
            check("R12", int'({hsync, vsync, frame_irq, mem_bank}), 0, -1);
            check("R12", int'(mem_addr), 0, -1);
        end
        rst_n = 1'b1;
        for (int q = 0; q < NFRAMES * LINE * FL; q++) begin
            @(negedge clk);
            model(q, ea, eb, ehs, evs, eirq, tag);
            check(tag, int'({colour_a, colour_b}), int'({ea, eb}), q);
            check("R1", int'({hsync, vsync}), int'({ehs, evs}), q);
            check("R9", int'(frame_irq), int'(eirq), q);
            h = (q + 1) % LINE;
            if (h == SAFE_H) begin
                l = ((q + 1) / LINE) % FL;
                f = (q + 1) / (LINE * FL);
                if (l == FL - 1) cfg(f + 1, 0);
                else cfg(f, l + 1);
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual still running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule